// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Controller

The block takes ten interrupt request lines, gives each one an enable and a two-bit priority, and gates them all with a global enable. At every instruction boundary the core signals, the block picks the single request that may be taken now and raises a one-cycle take pulse together with the winning source number. It also keeps an in-service record of the priority levels whose handlers are active, so that only a strictly more urgent request can preempt a running handler. A return strobe from the core retires the innermost handler.

The highest pending level always wins. Fixed source-number order, with the lowest number first, settles ties only among requests that share that top level. While the core sleeps (idle or power-down), any enabled request raises a wake output. The enable, global-enable and priority settings arrive as plain inputs. The block samples them into its own registers every clock, and reset clears those registers.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A request can be taken only when its own enable bit is set. Enable bit i belongs to request line i, and a request whose enable is clear is never taken.
- R2: When the global enable is clear, no request is taken, whatever the individual enables are.
- R3: A source's level is {prio_hi_i[i], prio_lo_i[i]} (0 to 3, with 3 the most urgent). Among qualifying requests, the highest level wins regardless of source number.
- R4: A request qualifies only if its level is strictly above the highest level now in service. When no level is in service, every enabled request qualifies.
- R5: While level 3 is in service, no request is taken.
- R6: Among qualifying requests at the top pending level, the lowest source number wins. A lower source number never beats a higher level.
- R7: take_o is a registered pulse. It is high for the cycle after a rising clock edge at which boundary_i was high and a qualifying request existed, and take_idx_o gives the winner in that same cycle. With boundary_i low, no take happens.
- R8: wake_o is high in the cycle after an edge at which sleep_i was high, the global enable was set, and at least one request had its enable set.
- R9: Taking a request marks its level as in service, so further requests at that level or below are held off.
- R10: A return strobe retires only the highest level in service. The lower levels stay in service.
- R11: Settings are registered and take effect one cycle after they are applied. Synchronous reset clears the enables, the priorities, the global enable, the in-service record, take_o, take_idx_o and wake_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 10 | Interrupt request lines, one per source |
| src_en_i | input | 10 | Per-source enable bits |
| glob_en_i | input | 1 | Global enable |
| prio_lo_i | input | 10 | Low priority bit per source |
| prio_hi_i | input | 10 | High priority bit per source |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| irq_ret_i | input | 1 | Return-from-handler strobe |
| sleep_i | input | 1 | Core is in idle or power-down |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| take_idx_o | output | 4 | Winning source number |
| wake_o | output | 1 | Wake request for the sleeping core |

## Verification
The assertions check, on every cycle, that:
- a take follows a boundary strobe and the global enable;
- the taken source was enabled and requesting;
- a winner always sits above every in-service level, and nothing wins while level 3 is active;
- a take marks its level and a return drops exactly one level;
- wake follows sleep.

Only the bench scenarios can show which source wins. That covers tie-breaking by source number inside a level against ranking across levels, correct nesting and unwinding over several takes and returns, and reset clearing the registered settings. The bench shows this by comparing against an arithmetic model across a long pseudo-random sweep and a set of directed cases.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = 2;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [NUM_LVL-1:0] lvl_mask_t;
endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [NUM_SRC-1:0]         src_en_i,
  input  logic                       glob_en_i,
  input  logic [NUM_SRC-1:0]         prio_lo_i,
  input  logic [NUM_SRC-1:0]         prio_hi_i,
  output logic [NUM_SRC-1:0]         en_q,
  output logic                       gen_q,
  output lvl_t [NUM_SRC-1:0]         lvl_q
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= '0;
      gen_q <= 1'b0;
    end else begin
      en_q  <= src_en_i;
      gen_q <= glob_en_i;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
    always_ff @(posedge clk_i) begin
      if (rst_i) lvl_q[i] <= '0;
      else       lvl_q[i] <= {prio_hi_i[i], prio_lo_i[i]};
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int IDX_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NUM_SRC-1:0]   req_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic                 gen_i,
  input  lvl_t [NUM_SRC-1:0]   lvl_i,
  input  lvl_mask_t            mask_i,
  output logic                 win_valid_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output lvl_t                 win_lvl_o
);
  logic               thr_none;
  lvl_t               thr_lvl;
  logic [NUM_SRC-1:0] qual;
  logic [NUM_SRC-1:0] lvl_hit [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_any;

  // Threshold: highest level currently in service.
  always_comb begin
    thr_none = ~|mask_i;
    thr_lvl  = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (mask_i[l]) thr_lvl = lvl_t'(l);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
    assign qual[i] = req_i[i] & en_i[i] & gen_i &
                     (thr_none | (lvl_i[i] > thr_lvl));
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign lvl_hit[l][i] = qual[i] & (lvl_i[i] == lvl_t'(l));
    end
    assign lvl_any[l] = |lvl_hit[l];
  end

  // Top pending level, then lowest source number inside it.
  always_comb begin
    win_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (lvl_any[l]) win_lvl_o = lvl_t'(l);
    win_idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (lvl_hit[win_lvl_o][i]) win_idx_o = IDX_W'(i);
    win_valid_o = |qual;
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_ast
    AST_ABOVE_INSERVICE: assert property (@(posedge clk_i) disable iff (rst_i)
      (win_valid_o && mask_i[l]) |-> (win_lvl_o > lvl_t'(l))); // R4
  end

  AST_NO_PREEMPT_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
    mask_i[NUM_LVL-1] |-> !win_valid_o); // R5
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
  import nic_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      take_i,
  input  lvl_t      take_lvl_i,
  input  logic      reti_i,
  output lvl_mask_t mask_q
);
  lvl_mask_t top_bit;
  lvl_mask_t set_bit;
  lvl_mask_t mask_d;

  always_comb begin
    top_bit = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (mask_q[l]) top_bit = lvl_mask_t'(1) << l;
    set_bit = take_i ? (lvl_mask_t'(1) << take_lvl_i) : '0;
    mask_d  = (reti_i ? (mask_q & ~top_bit) : mask_q) | set_bit;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) mask_q <= '0;
    else       mask_q <= mask_d;
  end

  AST_TAKE_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_i && !reti_i) |=> mask_q[$past(take_lvl_i)]); // R9

  AST_RETURN_DROPS_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (reti_i && !take_i && (mask_q != '0)) |=>
      ($countones(mask_q) + 1 == $countones($past(mask_q)))); // R10
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               glob_en_i,
  input  logic [NUM_SRC-1:0] prio_lo_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic               boundary_i,
  input  logic               irq_ret_i,
  input  logic               sleep_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_idx_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0] cfg_en;
  logic               cfg_gen;
  lvl_t [NUM_SRC-1:0] cfg_lvl;
  lvl_mask_t          svc_mask;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               take_d;
  logic [NUM_SRC-1:0] live_req;

  nic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .src_en_i  (src_en_i),
    .glob_en_i (glob_en_i),
    .prio_lo_i (prio_lo_i),
    .prio_hi_i (prio_hi_i),
    .en_q      (cfg_en),
    .gen_q     (cfg_gen),
    .lvl_q     (cfg_lvl)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (req_i),
    .en_i        (cfg_en),
    .gen_i       (cfg_gen),
    .lvl_i       (cfg_lvl),
    .mask_i      (svc_mask),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_lvl_o   (win_lvl)
  );

  assign take_d   = boundary_i & win_valid;
  assign live_req = req_i & cfg_en;

  nic_inservice u_svc (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .take_i     (take_d),
    .take_lvl_i (win_lvl),
    .reti_i     (irq_ret_i),
    .mask_q     (svc_mask)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      take_o     <= 1'b0;
      take_idx_o <= '0;
      wake_o     <= 1'b0;
    end else begin
      take_o <= take_d;
      if (take_d) take_idx_o <= win_idx;
      wake_o <= sleep_i & cfg_gen & (|live_req);
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> $past(boundary_i)); // R7

  AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> $past(cfg_gen)); // R2

  AST_TAKE_ENABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> |($past(live_req) & (NUM_SRC'(1) << take_idx_o))); // R1

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk_i) disable iff (rst_i)
    wake_o |-> $past(sleep_i)); // R8
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] req, en, lo, hi;
  logic         gen, bnd, ret, slp;
  logic         take, wake;
  logic [3:0]   tidx;

  int errs = 0;
  int checks = 0;
  logic [3:0]  mdl_mask = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .src_en_i(en), .glob_en_i(gen),
    .prio_lo_i(lo), .prio_hi_i(hi), .boundary_i(bnd), .irq_ret_i(ret),
    .sleep_i(slp), .take_o(take), .take_idx_o(tidx), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input logic [N-1:0] r, input logic [N-1:0] e, input logic g,
                       input logic [N-1:0] l, input logic [N-1:0] h);
    req = r; en = e; gen = g; lo = l; hi = h;
    step();
  endtask

  function automatic int model_win();
    int thr = -1;
    int best = -1;
    int bidx = -1;
    for (int l = 0; l < 4; l++) if (mdl_mask[l]) thr = l;
    for (int i = 0; i < N; i++) begin
      int lv = 2 * int'(hi[i]) + int'(lo[i]);
      if (req[i] && en[i] && gen && lv > thr && lv > best) begin
        best = lv;
        bidx = i;
      end
    end
    return bidx;
  endfunction

  task automatic try_take(input string tag, input bit exp_v, input int exp_idx);
    bnd = 1'b1;
    step();
    bnd = 1'b0;
    chk(take == exp_v, {tag, " take"}, int'(take), int'(exp_v));
    if (exp_v) begin
      chk(int'(tidx) == exp_idx, {tag, " index"}, int'(tidx), exp_idx);
      mdl_mask[2 * int'(hi[exp_idx]) + int'(lo[exp_idx])] = 1'b1;
    end
  endtask

  task automatic do_ret();
    ret = 1'b1;
    step();
    ret = 1'b0;
    for (int l = 3; l >= 0; l--)
      if (mdl_mask[l]) begin
        mdl_mask[l] = 1'b0;
        break;
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; bnd = 1'b0; ret = 1'b0; slp = 1'b0;
    req = '1; en = '1; gen = 1'b1; lo = '0; hi = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(take == 1'b0, "R11 reset take", int'(take), 0);
    chk(tidx == 4'd0, "R11 reset index", int'(tidx), 0);
    chk(wake == 1'b0, "R11 reset wake", int'(wake), 0);
    // First edge after reset still sees cleared settings.
    rst = 1'b0;
    try_take("R11 cleared settings", 1'b0, 0);
    // All at level 0: lowest number wins.
    try_take("R11 settings next cycle", 1'b1, 0);
    do_ret();

    // R2: global enable clear blocks everything
    apply('1, '1, 1'b0, '0, '0);
    try_take("R2 global off", 1'b0, 0);

    // R1: disabled source ignored, enabled one taken
    apply(10'h080, 10'h37F, 1'b1, '0, '0);
    try_take("R1 disabled", 1'b0, 0);
    apply(10'h080, 10'h3FF, 1'b1, '0, '0);
    try_take("R1 enabled", 1'b1, 7);
    do_ret();

    // R3: higher level beats lower number (9 at level 2, 0 at level 1)
    apply(10'h201, '1, 1'b1, 10'h001, 10'h200);
    try_take("R3 level beats rank", 1'b1, 9);
    do_ret();

    // R6: tie at level 2 between 4 and 6, 2 is lower at level 1
    apply(10'h054, '1, 1'b1, 10'h004, 10'h050);
    try_take("R6 tie lowest number", 1'b1, 4);
    do_ret();

    // R7: no boundary, no take
    apply(10'h008, '1, 1'b1, '0, '0);
    step();
    chk(take == 1'b0, "R7 no boundary", int'(take), 0);

    // R4/R9/R10 nesting: 3 at level 1, 5 at level 1, 8 at level 2
    apply(10'h008, '1, 1'b1, 10'h028, 10'h100);
    try_take("R4 first level 1", 1'b1, 3);
    apply(10'h020, '1, 1'b1, 10'h028, 10'h100);
    try_take("R9 same level held", 1'b0, 0);
    apply(10'h120, '1, 1'b1, 10'h028, 10'h100);
    try_take("R4 higher preempts", 1'b1, 8);
    do_ret();
    apply(10'h020, '1, 1'b1, 10'h028, 10'h100);
    try_take("R10 lower level still active", 1'b0, 0);
    do_ret();
    try_take("R10 all retired", 1'b1, 5);
    do_ret();

    // R5: level 3 in service blocks all
    apply(10'h002, '1, 1'b1, 10'h3FF, 10'h3FF);
    try_take("R5 enter level 3", 1'b1, 1);
    apply('1, '1, 1'b1, 10'h3FF, 10'h3FF);
    try_take("R5 nothing preempts", 1'b0, 0);
    do_ret();

    // R8: wake
    slp = 1'b1;
    apply(10'h010, 10'h010, 1'b1, '0, '0);
    step();
    chk(wake == 1'b1, "R8 wake enabled", int'(wake), 1);
    apply(10'h010, 10'h3EF, 1'b1, '0, '0);
    step();
    chk(wake == 1'b0, "R8 wake disabled source", int'(wake), 0);
    apply(10'h010, 10'h010, 1'b0, '0, '0);
    step();
    chk(wake == 1'b0, "R8 wake global off", int'(wake), 0);
    slp = 1'b0;
    step();
    chk(wake == 1'b0, "R8 awake", int'(wake), 0);

    // Sweep against the arithmetic model
    for (int t = 0; t < 600; t++) begin
      logic [31:0] a;
      logic [31:0] b;
      int w;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      b = seed;
      apply(a[9:0], a[19:10] | a[29:20], (a[31:30] != 2'b00), b[9:0], b[19:10]);
      w = model_win();
      try_take("R3/R4/R6 sweep", (w >= 0), (w >= 0) ? w : 0);
      if ((b[25] || mdl_mask[3]) && (mdl_mask != '0)) do_ret();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule